// File: doc/BRIEF.md
# GPIO port with edge interrupts

The block is an eight-pin general-purpose I/O port that sits on a simple synchronous register bus. Software gives each pin a direction, an output value, an edge polarity and an interrupt enable. Pins configured as outputs are driven from the output value register. All pin inputs are brought into the clock domain through a two-stage synchronizer.

A selected subset of pins records edges. Each of these pins latches a sticky flag when its synchronized input makes the transition chosen by its polarity bit. Software reads the flags and clears them by writing ones. A single registered interrupt line is raised while any flag is set together with its enable bit.

A read of the output value register returns the register bit for output pins and the synchronized pin level for input pins. Bus reads are registered: the read data reflects the address presented at the previous rising clock edge.

Top module: `gpio_edge_port`

## Requirements
- R1: While reset is high and on the first cycle after it, irq is 0 and every flag is 0. After reset, every register reads 0, pin_oe is 0 and pin_out is 0.
- R2: pin_oe equals the direction register at address 1. pin_out equals the output value register at address 0.
- R3: A read of address 0 returns the output value register bit where the direction bit is 1, and the synchronized pin input where the direction bit is 0. A pin change is visible in a read issued three cycles later.
- R4: With its polarity bit (address 2) at 0, a flag-capable pin sets its flag (address 4) on a 1-to-0 transition of its synchronized input, and does not set it on a 0-to-1 transition.
- R5: With its polarity bit at 1, a flag-capable pin sets its flag on a 0-to-1 transition, and does not set it on a 1-to-0 transition.
- R6: Writing 1 to a bit of the flag register clears that flag. Writing 0 leaves the flag unchanged.
- R7: When an active edge and a clearing write reach the same flag on the same clock edge, the flag ends up set.
- R8: Only bit positions 7, 6, 2, 1 and 0 carry flags (mask 0xC7). Bits 5 to 3 of the flag register always read 0, ignore edges on their pins and ignore writes.
- R9: irq is registered. It equals the OR over all bits of (flag AND enable) one cycle earlier, where enable is the register at address 3.
- R10: bus_rdata is registered and shows the register at the address presented on the previous clock edge. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address: 0 output value, 1 direction, 2 polarity, 3 enable, 4 flags |
| bus_wr | input | 1 | Write strobe for the current clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Output pin values |
| pin_oe | output | 8 | Output enables, 1 means drive |
| irq | output | 1 | Registered interrupt request |

## Verification
The edge logic is driven with single-pin pulses under both polarity settings. This shows that a flag responds to the selected transition only and that the opposite transition leaves it alone. A full-port toggle followed by a write of ones to bits 5 to 3 separates the implemented flag positions from the empty ones. A falling edge is timed so that it lands on the same edge as a clearing write; this tells a set-priority flag apart from a clear-priority one. Output value reads are taken with all pins as inputs, all pins as outputs and a mixed direction. These three cases show that each bit picks its source on its own, and the interrupt line is sampled one cycle before and one cycle after a flag appears to pin down its latency.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  typedef enum logic [2:0] {
    SEL_DATA = 3'd0,
    SEL_DIR  = 3'd1,
    SEL_POL  = 3'd2,
    SEL_IEN  = 3'd3,
    SEL_FLAG = 3'd4
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '0;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] FLAG_MASK = 8'hC7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] sync_val,
  input  logic [WIDTH-1:0] pol,
  input  logic [WIDTH-1:0] ien,
  input  logic [WIDTH-1:0] clr,
  output logic [WIDTH-1:0] hit,
  output logic [WIDTH-1:0] flags,
  output logic             irq
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] flag_q;
  logic [WIDTH-1:0] flag_d;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= sync_val;
  end

  // Per-bit edge select: polarity 1 picks rising, 0 picks falling.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_edge
      if (FLAG_MASK[i]) begin : g_live
        always_comb begin
          if (pol[i]) hit[i] = sync_val[i] & ~prev_q[i];
          else        hit[i] = ~sync_val[i] & prev_q[i];
        end
      end else begin : g_dead
        assign hit[i] = 1'b0;
      end
    end
  endgenerate

  // Set has priority over a same-cycle clear.
  always_comb begin
    flag_d = ((flag_q & ~clr) | hit) & FLAG_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= |(flag_q & ien);
    end
  end

  assign flags = flag_q;
  assign irq   = irq_q;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_edge_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  sync_val,
  input  logic [WIDTH-1:0]  flags,
  output logic [WIDTH-1:0]  data_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  pol_q,
  output logic [WIDTH-1:0]  ien_q,
  output logic [WIDTH-1:0]  clr,
  output logic [WIDTH-1:0]  rdata
);
  logic hit_data, hit_dir, hit_pol, hit_ien, hit_flag;
  logic [WIDTH-1:0] rd_mux;
  logic [WIDTH-1:0] port_view;

  assign hit_data = (addr == ADDR_W'(SEL_DATA));
  assign hit_dir  = (addr == ADDR_W'(SEL_DIR));
  assign hit_pol  = (addr == ADDR_W'(SEL_POL));
  assign hit_ien  = (addr == ADDR_W'(SEL_IEN));
  assign hit_flag = (addr == ADDR_W'(SEL_FLAG));

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (wr) begin
      if (hit_data) data_q <= wdata;
      if (hit_dir)  dir_q  <= wdata;
      if (hit_pol)  pol_q  <= wdata;
      if (hit_ien)  ien_q  <= wdata;
    end
  end

  assign clr       = (wr && hit_flag) ? wdata : '0;
  assign port_view = (data_q & dir_q) | (sync_val & ~dir_q);

  always_comb begin
    rd_mux = '0;
    if (hit_data) rd_mux = port_view;
    if (hit_dir)  rd_mux = dir_q;
    if (hit_pol)  rd_mux = pol_q;
    if (hit_ien)  rd_mux = ien_q;
    if (hit_flag) rd_mux = flags;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int               WIDTH       = 8,
  parameter int               ADDR_W      = 3,
  parameter int               SYNC_STAGES = 2,
  parameter logic [WIDTH-1:0] FLAG_MASK   = 8'hC7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              irq
);
  logic [WIDTH-1:0] sync_w;
  logic [WIDTH-1:0] data_w, dir_w, pol_w, ien_w, clr_w, hit_w, flag_w;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(sync_w)
  );

  gpio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .sync_val(sync_w), .flags(flag_w),
    .data_q(data_w), .dir_q(dir_w), .pol_q(pol_w), .ien_q(ien_w),
    .clr(clr_w), .rdata(bus_rdata)
  );

  gpio_edge_flags #(.WIDTH(WIDTH), .FLAG_MASK(FLAG_MASK)) u_flags (
    .clk(clk), .rst(rst), .sync_val(sync_w), .pol(pol_w), .ien(ien_w),
    .clr(clr_w), .hit(hit_w), .flags(flag_w), .irq(irq)
  );

  assign pin_out = data_w;
  assign pin_oe  = dir_w;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int               WIDTH     = 8,
  parameter logic [WIDTH-1:0] FLAG_MASK = 8'hC7
) (
  input logic             clk,
  input logic             rst,
  input logic             irq,
  input logic [WIDTH-1:0] flags,
  input logic [WIDTH-1:0] ien,
  input logic [WIDTH-1:0] hit,
  input logic [WIDTH-1:0] clr
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && flags == '0));

  // R9
  irq_latency_chk: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(flags & ien)));

  // R8
  empty_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (flags & ~FLAG_MASK) == '0);

  // R6
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~hit & FLAG_MASK)) |=> ((flags & $past(clr & ~hit & FLAG_MASK)) == '0));

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|(hit & FLAG_MASK)) |=> ((flags & $past(hit & FLAG_MASK)) == $past(hit & FLAG_MASK)));
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.WIDTH(WIDTH), .FLAG_MASK(FLAG_MASK)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .flags(flag_w), .ien(ien_w),
  .hit(hit_w), .clr(clr_w)
);

// File: tb/gpio_edge_port_bench.sv
`timescale 1ns/1ps
module gpio_edge_port_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = '0;
  logic [7:0] pin_out, pin_oe;
  logic       irq;

  int checks = 0;
  int errors = 0;

  gpio_edge_port u_gpio_edge_port (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      chk((a > 4) ? "R10 unmapped read" : "R1 reset value", v, 8'h00);
    end
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    chk("R1 pin_oe after reset", pin_oe, 8'h00);
    chk("R1 pin_out after reset", pin_out, 8'h00);
  endtask

  task automatic t_data_dir;
    logic [7:0] v;
    pin_in = 8'h5A; cyc(3);
    rd(3'd0, v); chk("R3 input read", v, 8'h5A);
    wr(3'd0, 8'hC3); wr(3'd1, 8'hFF);
    rd(3'd0, v); chk("R3 output read", v, 8'hC3);
    chk("R2 pin_out", pin_out, 8'hC3);
    chk("R2 pin_oe", pin_oe, 8'hFF);
    wr(3'd1, 8'hF0);
    rd(3'd0, v); chk("R3 mixed read", v, 8'hCA);
    chk("R2 pin_oe mixed", pin_oe, 8'hF0);
    rd(3'd1, v); chk("R10 dir readback", v, 8'hF0);
    pin_in = 8'h00; wr(3'd1, 8'h00); cyc(3);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R6 flags cleared", v, 8'h00);
  endtask

  task automatic t_falling;
    logic [7:0] v;
    pin_in[1] = 1'b1; cyc(4);
    rd(3'd4, v); chk("R4 rising ignored", v, 8'h00);
    pin_in[1] = 1'b0; cyc(4);
    rd(3'd4, v); chk("R4 falling sets", v, 8'h02);
  endtask

  task automatic t_rising;
    logic [7:0] v;
    wr(3'd2, 8'h40);
    rd(3'd2, v); chk("R10 pol readback", v, 8'h40);
    pin_in[6] = 1'b1; cyc(4);
    rd(3'd4, v); chk("R5 rising sets", v, 8'h42);
    wr(3'd4, 8'h40);
    pin_in[6] = 1'b0; cyc(4);
    rd(3'd4, v); chk("R5 falling ignored", v, 8'h02);
    pin_in[6] = 1'b1; cyc(4);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_w1c;
    logic [7:0] v;
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R6 write zero keeps", v, 8'h42);
    wr(3'd4, 8'h02);
    rd(3'd4, v); chk("R6 clear one bit", v, 8'h40);
    wr(3'd4, 8'h40);
    rd(3'd4, v); chk("R6 clear last", v, 8'h00);
  endtask

  task automatic t_set_wins;
    logic [7:0] v;
    pin_in[0] = 1'b1; cyc(4);
    pin_in[0] = 1'b0; cyc(4);
    rd(3'd4, v); chk("R7 pre-set flag", v & 8'h01, 8'h01);
    pin_in[0] = 1'b1; cyc(4);
    pin_in[0] = 1'b0;
    cyc(2);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R7 set beats clear", v & 8'h01, 8'h01);
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R7 later clear works", v & 8'h01, 8'h00);
  endtask

  task automatic t_mask;
    logic [7:0] v;
    wr(3'd4, 8'hFF);
    pin_in = 8'hFF; cyc(4);
    pin_in = 8'h00; cyc(4);
    rd(3'd4, v); chk("R8 implemented flags", v, 8'hC7);
    wr(3'd4, 8'h38);
    rd(3'd4, v); chk("R8 empty bits ignore write", v, 8'hC7);
    wr(3'd4, 8'hFF);
    rd(3'd4, v); chk("R8 all cleared", v, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(3'd3, 8'h04);
    rd(3'd3, v); chk("R10 enable readback", v, 8'h04);
    pin_in[2] = 1'b1; cyc(4);
    chk("R9 idle irq", {7'd0, irq}, 8'h00);
    pin_in[2] = 1'b0;
    cyc(3);
    chk("R9 irq one cycle late", {7'd0, irq}, 8'h00);
    cyc(1);
    chk("R9 irq raised", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h00); cyc(1);
    chk("R9 irq masked", {7'd0, irq}, 8'h00);
    wr(3'd3, 8'h04); cyc(1);
    chk("R9 irq re-enabled", {7'd0, irq}, 8'h01);
    wr(3'd4, 8'h04); cyc(1);
    chk("R9 irq after clear", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_data_dir();
    t_falling();
    t_rising();
    t_w1c();
    t_set_wins();
    t_mask();
    t_irq();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule